// File: doc/BRIEF.md
# Inter-Thread FIFO Storage Cell

This block is one shared storage cell through which several hardware threads pass data words to each other. The words sit in a small first-in, first-out queue. Every request carries a two-bit view code, taken from address bits, that selects how the access behaves:

- **Raw view:** reads and writes the queue contents without moving any pointer.
- **Blocking queue view:** pushes and pops, and stalls the requester when it cannot proceed.
- **Non-blocking queue view:** pushes and pops, and never stalls.
- **Tag view:** reads and writes the cell's status tag.

The response data and the stall flag are combinational, so they are valid in the same cycle as the request. All state changes on the following rising clock edge.

When a blocking access stalls, the cell records the requesting thread in a bitmap of waiting threads. Each stalled thread is kept as waiting either for data or for space. A later access that makes data or space available clears the matching group, so those threads can retry.

Top module: `itc_fifo_cell`

## Requirements
- R1: After reset the cell is empty: `tagEmpty`=1, `tagFull`=0 and `blockedMap`=0.
- R2: In the blocking (view 2) and non-blocking (view 3) queue views, a write pushes a word and a read pops and returns the oldest word, in first-in, first-out order.
- R3: `tagFull` rises once DEPTH words are held, and `tagEmpty` rises again once all of them are popped.
- R4: A view-2 read of an empty cell raises `rspStall` in the request cycle and returns 0. The queue is left unchanged, and bit `reqThread` of `blockedMap` is set from the next cycle.
- R5: A view-2 write to a full cell raises `rspStall`, does not store the word, and sets bit `reqThread` of `blockedMap`.
- R6: View 3 never stalls. A write to a full cell is dropped and the contents are kept. A read of an empty cell returns 0.
- R7: A view-0 (raw) read returns the oldest word without removing it, and leaves `tagEmpty`/`tagFull` unchanged.
- R8: A view-0 write replaces the newest held word rather than adding one, never stalls, and leaves the word count unchanged.
- R9: A view-1 (tag) read never stalls and returns a word whose only possibly-set bits are:
  - bit 0 = empty;
  - bit 1 = full;
  - bit 2 = a constant 1 that marks the cell as a queue.
- R10: A view-1 write with bit 0 set empties the queue. A view-1 write with bit 0 clear has no effect.
- R11: A completed push clears every thread waiting for data. A completed pop, or an emptying tag write, clears every thread waiting for space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqView | input | 2 | Access view: 0 raw, 1 tag, 2 blocking queue, 3 non-blocking queue |
| reqThread | input | TID_W | Requesting thread index |
| reqWdata | input | DATA_W | Write data |
| rspRdata | output | DATA_W | Read data, same cycle |
| rspStall | output | 1 | Requester must stall, same cycle |
| tagEmpty | output | 1 | Cell holds no words |
| tagFull | output | 1 | Cell holds DEPTH words |
| blockedMap | output | NUM_THREADS | One bit per thread that is stalled on the cell |

## Verification
The in-line properties check, on every cycle, the following invariants:
- the word count never exceeds DEPTH, and no push ever lands on a full queue;
- a stall occurs only in view 2 against the matching empty or full condition;
- a stall always leaves the requester's bit set in the next cycle;
- a push always clears the waiting-for-data group.

Data ordering, the raw-view read and overwrite semantics, the dropped non-blocking write, and the tag word layout and flush can only be shown by the directed scenarios. These scenarios compare the returned words against a known sequence.

// File: rtl/itc_fifo_pkg.sv
package itc_fifo_pkg;
  typedef enum logic [1:0] {
    VIEW_RAW   = 2'd0,
    VIEW_TAG   = 2'd1,
    VIEW_BLOCK = 2'd2,
    VIEW_TRY   = 2'd3
  } viewE;

  localparam int TAG_EMPTY_BIT = 0;
  localparam int TAG_FULL_BIT  = 1;
  localparam int TAG_QUEUE_BIT = 2;

  typedef struct packed {
    logic push;
    logic pop;
    logic overwrite;
    logic flush;
  } cellStrbT;
endpackage

// File: rtl/itc_fifo_data.sv
module itc_fifo_data
  import itc_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  cellStrbT          strb,
  input  logic [DATA_W-1:0] wData,
  output logic [DATA_W-1:0] headData,
  output logic              isEmpty,
  output logic              isFull
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr, newestIdx;
  logic [CNT_W-1:0]  count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign newestIdx = (wrPtr == '0) ? LAST_IDX : wrPtr - 1'b1;
  assign headData  = mem[rdPtr];
  assign isEmpty   = (count == '0);
  assign isFull    = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (strb.push)           mem[wrPtr]     <= wData;
    else if (strb.overwrite) mem[newestIdx] <= wData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= bump(wrPtr);
      if (strb.pop)  rdPtr <= bump(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  p_no_push_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> !isFull);
  p_no_pop_empty_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> !isEmpty);
  p_raw_keeps_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.push && !strb.pop && !strb.flush) |=> $stable(count));
  p_push_grows_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && !strb.flush) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/itc_fifo_ctrl.sv
module itc_fifo_ctrl
  import itc_fifo_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_THREADS = 4,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [1:0]             reqView,
  input  logic [TID_W-1:0]       reqThread,
  input  logic [DATA_W-1:0]      reqWdata,
  input  logic [DATA_W-1:0]      headData,
  input  logic                   isEmpty,
  input  logic                   isFull,
  output cellStrbT               strb,
  output logic [DATA_W-1:0]      rspRdata,
  output logic                   rspStall,
  output logic [NUM_THREADS-1:0] blockedMap
);
  logic [NUM_THREADS-1:0] waitData, waitSpace, nextData, nextSpace;
  logic [DATA_W-1:0]      tagWord;
  viewE                   view;

  assign view = viewE'(reqView);

  always_comb begin
    tagWord = '0;
    tagWord[TAG_EMPTY_BIT] = isEmpty;
    tagWord[TAG_FULL_BIT]  = isFull;
    tagWord[TAG_QUEUE_BIT] = 1'b1;
  end

  always_comb begin
    strb     = '0;
    rspStall = 1'b0;
    rspRdata = '0;
    if (reqValid) begin
      unique case (view)
        VIEW_RAW: begin
          if (reqWrite) strb.overwrite = 1'b1;
          else          rspRdata = headData;
        end
        VIEW_TAG: begin
          if (reqWrite) strb.flush = reqWdata[TAG_EMPTY_BIT];
          else          rspRdata = tagWord;
        end
        VIEW_BLOCK: begin
          if (reqWrite) begin
            if (isFull) rspStall = 1'b1;
            else        strb.push = 1'b1;
          end else if (isEmpty) begin
            rspStall = 1'b1;
          end else begin
            strb.pop = 1'b1;
            rspRdata = headData;
          end
        end
        VIEW_TRY: begin
          if (reqWrite) strb.push = !isFull;
          else if (!isEmpty) begin
            strb.pop = 1'b1;
            rspRdata = headData;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    nextData  = waitData;
    nextSpace = waitSpace;
    if (strb.push)              nextData  = '0;
    if (strb.pop || strb.flush) nextSpace = '0;
    if (rspStall && reqWrite)   nextSpace[reqThread] = 1'b1;
    if (rspStall && !reqWrite)  nextData[reqThread]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitData  <= '0;
      waitSpace <= '0;
    end else begin
      waitData  <= nextData;
      waitSpace <= nextSpace;
    end
  end

  assign blockedMap = waitData | waitSpace;

  p_stall_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspStall |-> (view == VIEW_BLOCK) && (reqWrite ? isFull : isEmpty));
  p_stall_marks_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspStall |=> blockedMap[$past(reqThread)]);
  p_push_wakes_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> waitData == '0);
  p_try_nostall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && view == VIEW_TRY) |-> !rspStall);
endmodule

// File: rtl/itc_fifo_cell.sv
module itc_fifo_cell
  import itc_fifo_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int DEPTH       = 4,
  parameter int NUM_THREADS = 4,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [1:0]             reqView,
  input  logic [TID_W-1:0]       reqThread,
  input  logic [DATA_W-1:0]      reqWdata,
  output logic [DATA_W-1:0]      rspRdata,
  output logic                   rspStall,
  output logic                   tagEmpty,
  output logic                   tagFull,
  output logic [NUM_THREADS-1:0] blockedMap
);
  cellStrbT          strb;
  logic [DATA_W-1:0] headData;

  itc_fifo_ctrl #(.DATA_W(DATA_W), .NUM_THREADS(NUM_THREADS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqView(reqView), .reqThread(reqThread), .reqWdata(reqWdata),
    .headData(headData), .isEmpty(tagEmpty), .isFull(tagFull),
    .strb(strb), .rspRdata(rspRdata), .rspStall(rspStall),
    .blockedMap(blockedMap)
  );

  itc_fifo_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wData(reqWdata),
    .headData(headData), .isEmpty(tagEmpty), .isFull(tagFull)
  );
endmodule

// File: tb/itc_fifo_cell_bench.sv
module itc_fifo_cell_bench;
  localparam int DW = 32, DEPTH = 4, NT = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]    reqView = '0;
  logic [1:0]    reqThread = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [DW-1:0] rspRdata;
  logic          rspStall, tagEmpty, tagFull;
  logic [NT-1:0] blockedMap;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [DW-1:0] gotData;
  logic          gotStall;

  always #5 clk = ~clk;

  itc_fifo_cell #(.DATA_W(DW), .DEPTH(DEPTH), .NUM_THREADS(NT)) u_itc_fifo_cell (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqView(reqView), .reqThread(reqThread), .reqWdata(reqWdata),
    .rspRdata(rspRdata), .rspStall(rspStall), .tagEmpty(tagEmpty),
    .tagFull(tagFull), .blockedMap(blockedMap)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access: drive at negedge, sample response mid-cycle, commit at posedge
  task automatic acc(input logic [1:0] v, input logic w, input logic [1:0] tid, input logic [DW-1:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqView = v; reqWrite = w; reqThread = tid; reqWdata = d;
    #1;
    gotData = rspRdata; gotStall = rspStall;
    @(posedge clk); #1;
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic tReset();
    doReset();
    chk(tagEmpty == 1'b1, "R1 empty", DW'(tagEmpty), 1);
    chk(tagFull == 1'b0, "R1 full", DW'(tagFull), 0);
    chk(blockedMap == '0, "R1 blocked", DW'(blockedMap), 0);
  endtask

  task automatic tOrder();
    doReset();
    for (int i = 0; i < DEPTH; i++) acc(2'd2, 1'b1, 2'd0, 32'hA000 + DW'(i));
    chk(tagFull == 1'b1, "R3 full after DEPTH pushes", DW'(tagFull), 1);
    for (int i = 0; i < DEPTH; i++) begin
      acc((i % 2 == 0) ? 2'd2 : 2'd3, 1'b0, 2'd1, '0);
      chk(gotData == 32'hA000 + DW'(i), "R2 pop order", gotData, 32'hA000 + DW'(i));
    end
    chk(tagEmpty == 1'b1, "R3 empty after drain", DW'(tagEmpty), 1);
  endtask

  task automatic tBlock();
    doReset();
    acc(2'd2, 1'b0, 2'd2, '0);
    chk(gotStall == 1'b1, "R4 stall on empty read", DW'(gotStall), 1);
    chk(gotData == '0, "R4 data on stall", gotData, 0);
    chk(blockedMap == 4'b0100, "R4 blocked bit", DW'(blockedMap), 32'h4);
    chk(tagEmpty == 1'b1, "R4 still empty", DW'(tagEmpty), 1);
    acc(2'd3, 1'b1, 2'd0, 32'h11);
    chk(blockedMap == '0, "R11 push wakes readers", DW'(blockedMap), 0);
    for (int i = 1; i < DEPTH; i++) acc(2'd2, 1'b1, 2'd0, 32'h11 + DW'(i));
    acc(2'd2, 1'b1, 2'd3, 32'hDEAD);
    chk(gotStall == 1'b1, "R5 stall on full write", DW'(gotStall), 1);
    chk(blockedMap == 4'b1000, "R5 blocked bit", DW'(blockedMap), 32'h8);
    acc(2'd2, 1'b0, 2'd1, '0);
    chk(gotData == 32'h11, "R2 head after stall", gotData, 32'h11);
    chk(blockedMap == '0, "R11 pop wakes writers", DW'(blockedMap), 0);
    for (int i = 1; i < DEPTH; i++) begin
      acc(2'd2, 1'b0, 2'd1, '0);
      chk(gotData == 32'h11 + DW'(i), "R5 full write not stored", gotData, 32'h11 + DW'(i));
    end
  endtask

  task automatic tTry();
    doReset();
    acc(2'd3, 1'b0, 2'd1, '0);
    chk(gotStall == 1'b0 && gotData == '0, "R6 empty read", gotData, 0);
    for (int i = 0; i < DEPTH; i++) acc(2'd3, 1'b1, 2'd0, 32'hB0 + DW'(i));
    acc(2'd3, 1'b1, 2'd2, 32'hBAD);
    chk(gotStall == 1'b0, "R6 no stall on full", DW'(gotStall), 0);
    chk(blockedMap == '0, "R6 not blocked", DW'(blockedMap), 0);
    for (int i = 0; i < DEPTH; i++) begin
      acc(2'd3, 1'b0, 2'd1, '0);
      chk(gotData == 32'hB0 + DW'(i), "R6 drop kept contents", gotData, 32'hB0 + DW'(i));
    end
  endtask

  task automatic tRaw();
    doReset();
    acc(2'd2, 1'b1, 2'd0, 32'hC1);
    acc(2'd2, 1'b1, 2'd0, 32'hC2);
    acc(2'd0, 1'b0, 2'd1, '0);
    chk(gotData == 32'hC1, "R7 raw read oldest", gotData, 32'hC1);
    chk(tagEmpty == 1'b0 && tagFull == 1'b0, "R7 flags kept", {tagFull, tagEmpty}, 0);
    acc(2'd0, 1'b1, 2'd1, 32'hC9);
    chk(gotStall == 1'b0, "R8 raw write no stall", DW'(gotStall), 0);
    acc(2'd2, 1'b0, 2'd1, '0);
    chk(gotData == 32'hC1, "R7 raw read did not pop", gotData, 32'hC1);
    acc(2'd2, 1'b0, 2'd1, '0);
    chk(gotData == 32'hC9, "R8 newest replaced", gotData, 32'hC9);
    chk(tagEmpty == 1'b1, "R8 count unchanged", DW'(tagEmpty), 1);
  endtask

  task automatic tTag();
    doReset();
    acc(2'd1, 1'b0, 2'd0, '0);
    chk(gotData == 32'h5 && !gotStall, "R9 tag empty", gotData, 32'h5);
    for (int i = 0; i < DEPTH; i++) acc(2'd2, 1'b1, 2'd0, DW'(i));
    acc(2'd2, 1'b1, 2'd2, 32'h77);
    acc(2'd1, 1'b0, 2'd0, '0);
    chk(gotData == 32'h6, "R9 tag full", gotData, 32'h6);
    acc(2'd1, 1'b1, 2'd0, 32'hFFFF_FFFE);
    chk(tagFull == 1'b1, "R10 bit0 clear no effect", DW'(tagFull), 1);
    acc(2'd1, 1'b1, 2'd0, 32'h1);
    chk(tagEmpty == 1'b1, "R10 flush empties", DW'(tagEmpty), 1);
    chk(blockedMap == '0, "R11 flush wakes writers", DW'(blockedMap), 0);
  endtask

  initial begin
    tReset();
    tOrder();
    tBlock();
    tTry();
    tRaw();
    tTag();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule